// File: doc/BRIEF.md
# Multi-Initiator Cache Maintenance Queue

This block is the command front end of an outer cache that several CPUs share for maintenance work. Each CPU sets up a command through a small register bus whose every access carries the index of the requesting CPU. The command is built in one shared set of registers: an operation word, a start address and a size. The first CPU to write the operation word gains exclusive use of the shared set. It gives that right up when it reads its own registration status. That read either places the command in a small in-order queue or reports why the command was refused.

A stub engine takes commands from the queue one at a time and dispatches them on a set of ports. It answers each one with a done pulse after a fixed latency. If a CPU asked for notification, its private completion flag is raised when its command finishes. A read of the sync register is held off until every accepted command has finished.

The bus handshake works as follows. The requester raises `bus_req` for a single cycle. `bus_ack` pulses one cycle later, with `bus_rdata` valid for reads. The only exception is a read of the sync register, whose acknowledge waits for the drain. The requester issues no new access until the acknowledge arrives.

Top module: `maint_cmd_queue`

## Requirements
- R1: Register select 0 is the operation word. Bits 1:0 carry the operation (0 invalidate, 1 clean, 2 flush) and appear unchanged on `disp_op`. Bits 18:17 pick the region: 0 is the address range given by select 1 (start) and select 2 (size), and 1 is the whole cache. A whole-cache command dispatches with `disp_whole` high and with address and size both zero, whatever was written to selects 1 and 2.
- R2: When no CPU holds the command registers, a write to select 0 gives ownership to the writing CPU. While that CPU owns them, writes to selects 0, 1 and 2 from any other CPU fail and leave the owner's command unchanged.
- R3: A read of select 3 returns that CPU's registration status. Bit 0 is set when the CPU is not the owner, or when it has had a failed write since it last took ownership. Bit 1 is set when the CPU is the owner and the queue is full. The read clears that CPU's failure record, and it releases ownership if that CPU is the owner.
- R4: A command enters the queue exactly when its owner reads select 3 and both status bits are zero. A refused command is never dispatched.
- R5: The queue holds DEPTH commands. With DEPTH entries waiting, the owner's status read returns 2 and nothing is queued.
- R6: Commands are dispatched one at a time, in the order they were accepted, whatever CPU issued them. `disp_valid` pulses for one cycle and `disp_cpu` names the issuer.
- R7: `eng_done` pulses exactly LAT cycles after the matching `disp_valid` pulse.
- R8: Select 4 is a per-CPU status register whose bit 2 is the completion flag. The flag is set only when a command with bit 15 of its operation word set completes, and only for the CPU that issued that command. Writing 1 to bit 2 clears the calling CPU's flag.
- R9: A read of select 5 (the sync register, where 0x8 is written to request a drain) is acknowledged only after the queue is empty and the engine is idle.
- R10: After reset no CPU owns the registers, the queue is empty, all completion flags read 0 and a status read of select 3 returns 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Single-cycle access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_cpu | input | CW | Index of the requesting CPU |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access completed |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| disp_valid | output | 1 | Command dispatched to the engine |
| disp_op | output | 2 | Dispatched operation |
| disp_whole | output | 1 | Dispatched command covers the whole cache |
| disp_addr | output | AW | Dispatched start address |
| disp_size | output | AW | Dispatched size |
| disp_cpu | output | CW | Issuer of the dispatched command |
| eng_done | output | 1 | Engine finished the current command |

## Verification
The hardest state to reach is a full queue that still holds every refused command back. Reaching it needs a slow engine and several registrations that finish back to back. The bench therefore sets the engine latency far above the time one registration takes over the bus. It then alternates CPUs through six registrations, so that one command sits in the engine and four wait in the queue. Contention for the lock is set up by interleaving a second CPU's writes between the owner's setup writes and its status read. The scoreboard then checks that only the owner's values reach dispatch.

// File: rtl/maint_cmd_queue.sv
module maint_cmd_queue #(
  parameter int NCPU  = 2,
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int LAT   = 4,
  localparam int CW   = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_wr,
  input  logic [CW-1:0] bus_cpu,
  input  logic [2:0]    bus_sel,
  input  logic [31:0]   bus_wdata,
  output logic          bus_ack,
  output logic [31:0]   bus_rdata,
  output logic          disp_valid,
  output logic [1:0]    disp_op,
  output logic          disp_whole,
  output logic [AW-1:0] disp_addr,
  output logic [AW-1:0] disp_size,
  output logic [CW-1:0] disp_cpu,
  output logic          eng_done
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(LAT + 1);
  localparam int EW = CW + 4 + 2 * AW;
  localparam logic [2:0] SEL_MODE = 3'd0, SEL_ADDR = 3'd1, SEL_SIZE = 3'd2,
                         SEL_RSTAT = 3'd3, SEL_QSTAT = 3'd4, SEL_PRIM = 3'd5;
  localparam logic [PW:0] FULL_CNT = DEPTH[PW:0];

  logic [31:0]     mode_q;
  logic [AW-1:0]   addr_q, size_q;
  logic            owner_vld;
  logic [CW-1:0]   owner_id;
  logic [NCPU-1:0] fail_q, done_q;
  logic [EW-1:0]   fifo [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [PW:0]     cnt;
  logic            busy, disp_notify, pend_prim;
  logic [LW-1:0]   lcnt;

  wire rd      = bus_req && !bus_wr;
  wire wr      = bus_req && bus_wr;
  wire own     = owner_vld && owner_id == bus_cpu;
  wire rs_rd   = rd && bus_sel == SEL_RSTAT;
  wire full_b  = own && cnt == FULL_CNT;
  wire lost_b  = !own || fail_q[bus_cpu];
  wire push    = rs_rd && !full_b && !lost_b;
  wire pop     = !busy && cnt != '0;
  wire whole   = mode_q[18:17] == 2'd1;
  wire drained = cnt == '0 && !busy;
  wire finish  = busy && lcnt == '0;
  wire cmd_wr  = wr && (bus_sel == SEL_MODE || bus_sel == SEL_ADDR || bus_sel == SEL_SIZE);
  wire [EW-1:0] new_entry = {bus_cpu, mode_q[15], whole, mode_q[1:0],
                             whole ? '0 : addr_q, whole ? '0 : size_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_vld <= 1'b0;
      owner_id  <= '0;
      fail_q    <= '0;
      mode_q    <= '0;
      addr_q    <= '0;
      size_q    <= '0;
    end else begin
      if (cmd_wr) begin
        if (!owner_vld && bus_sel == SEL_MODE) begin
          owner_vld        <= 1'b1;
          owner_id         <= bus_cpu;
          mode_q           <= bus_wdata;
          fail_q[bus_cpu]  <= 1'b0;
        end else if (own) begin
          case (bus_sel)
            SEL_MODE: mode_q <= bus_wdata;
            SEL_ADDR: addr_q <= AW'(bus_wdata);
            default:  size_q <= AW'(bus_wdata);
          endcase
        end else begin
          fail_q[bus_cpu] <= 1'b1;
        end
      end
      if (rs_rd) begin
        fail_q[bus_cpu] <= 1'b0;
        if (own) owner_vld <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) fifo[wp] <= new_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      lcnt        <= '0;
      disp_valid  <= 1'b0;
      eng_done    <= 1'b0;
      disp_op     <= '0;
      disp_whole  <= 1'b0;
      disp_addr   <= '0;
      disp_size   <= '0;
      disp_cpu    <= '0;
      disp_notify <= 1'b0;
      done_q      <= '0;
    end else begin
      disp_valid <= 1'b0;
      eng_done   <= 1'b0;
      if (busy) begin
        if (finish) begin
          busy     <= 1'b0;
          eng_done <= 1'b1;
        end else begin
          lcnt <= lcnt - 1'b1;
        end
      end else if (pop) begin
        busy       <= 1'b1;
        lcnt       <= LW'(LAT - 1);
        disp_valid <= 1'b1;
        {disp_cpu, disp_notify, disp_whole, disp_op, disp_addr, disp_size} <= fifo[rp];
      end
      for (int c = 0; c < NCPU; c++) begin
        if (wr && bus_sel == SEL_QSTAT && bus_wdata[2] && bus_cpu == CW'(c)) done_q[c] <= 1'b0;
        if (finish && disp_notify && disp_cpu == CW'(c)) done_q[c] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
      pend_prim <= 1'b0;
    end else begin
      bus_ack   <= (bus_req && !(rd && bus_sel == SEL_PRIM)) || (pend_prim && drained);
      pend_prim <= pend_prim ? !drained : (rd && bus_sel == SEL_PRIM);
      if (rd) begin
        case (bus_sel)
          SEL_MODE:  bus_rdata <= mode_q;
          SEL_ADDR:  bus_rdata <= 32'(addr_q);
          SEL_SIZE:  bus_rdata <= 32'(size_q);
          SEL_RSTAT: bus_rdata <= {30'd0, full_b, lost_b};
          SEL_QSTAT: bus_rdata <= {29'd0, done_q[bus_cpu], 2'd0};
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt < FULL_CNT);
  // R6
  single_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !$past(busy));
  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> ($past(busy) && !busy));
  // R1
  whole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_whole) |-> (disp_addr == '0 && disp_size == '0));
  // R2
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_vld && !(rs_rd && bus_cpu == owner_id)) |=> (owner_vld && $stable(owner_id)));
  // R9
  sync_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_prim) && bus_ack) |-> $past(drained));
endmodule

// File: tb/maint_cmd_queue_test.sv
module maint_cmd_queue_test;
  localparam int NCPU = 2, DEPTH = 4, AW = 32, LAT = 200, CW = 1;
  localparam logic [2:0] S_MODE = 0, S_ADDR = 1, S_SIZE = 2, S_RSTAT = 3, S_QSTAT = 4, S_PRIM = 5;

  typedef struct packed {
    logic [1:0] op; logic whole; logic [AW-1:0] addr; logic [AW-1:0] size; logic [CW-1:0] cpu;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_wr = 0;
  logic [CW-1:0] bus_cpu = 0;
  logic [2:0] bus_sel = 0;
  logic [31:0] bus_wdata = 0;
  logic bus_ack, disp_valid, disp_whole, eng_done;
  logic [31:0] bus_rdata;
  logic [1:0] disp_op;
  logic [AW-1:0] disp_addr, disp_size;
  logic [CW-1:0] disp_cpu;

  int checks = 0, fails = 0, cyc = 0, disp_cyc = 0, n_disp = 0, n_done = 0;
  bit finished = 0;
  item_t exp_q[$];

  maint_cmd_queue #(.NCPU(NCPU), .DEPTH(DEPTH), .AW(AW), .LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_cpu(bus_cpu),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .disp_valid(disp_valid), .disp_op(disp_op), .disp_whole(disp_whole),
    .disp_addr(disp_addr), .disp_size(disp_size), .disp_cpu(disp_cpu), .eng_done(eng_done));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(bit w, int cpu, logic [2:0] sel, logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    bus_req = 1; bus_wr = w; bus_cpu = CW'(cpu); bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_req = 0;
    while (!bus_ack) @(negedge clk);
    r = bus_rdata;
  endtask

  task automatic submit(int cpu, logic [31:0] mode, logic [31:0] a, logic [31:0] s,
                        logic [31:0] exp_stat, string req);
    logic [31:0] r;
    item_t it;
    bus(1, cpu, S_MODE, mode, r);
    bus(1, cpu, S_ADDR, a, r);
    bus(1, cpu, S_SIZE, s, r);
    bus(0, cpu, S_RSTAT, 0, r);
    check(r == exp_stat, req, r, exp_stat);
    if (exp_stat == 0) begin
      it.op = mode[1:0]; it.whole = (mode[18:17] == 2'd1);
      it.addr = it.whole ? '0 : a; it.size = it.whole ? '0 : s; it.cpu = CW'(cpu);
      exp_q.push_back(it);
    end
  endtask

  task automatic sync(int cpu);
    logic [31:0] r;
    bus(1, cpu, S_PRIM, 32'h8, r);
    bus(0, cpu, S_PRIM, 0, r);
    // R9: all accepted work finished when the sync read returns
    check(exp_q.size() == 0 && n_done == n_disp && !disp_valid, "R9", n_done, n_disp);
  endtask

  // Scoreboard monitor: R1, R6, R7
  always @(negedge clk) begin
    if (rst_n && disp_valid) begin
      n_disp++;
      disp_cyc = cyc;
      if (exp_q.size() == 0) check(0, "R4 unexpected dispatch", disp_addr, 0);
      else begin
        item_t e;
        e = exp_q.pop_front();
        check(disp_op == e.op && disp_whole == e.whole, "R1", {disp_op, disp_whole}, {e.op, e.whole});
        check(disp_addr == e.addr && disp_size == e.size, "R1 R2", disp_addr, e.addr);
        check(disp_cpu == e.cpu, "R6", disp_cpu, e.cpu);
      end
    end
    if (rst_n && eng_done) begin
      n_done++;
      check(cyc - disp_cyc == LAT, "R7", cyc - disp_cyc, LAT);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    check(!bus_ack && !disp_valid, "R10", {bus_ack, disp_valid}, 0);
    bus(0, 0, S_QSTAT, 0, r); check(r == 0, "R10", r, 0);
    bus(0, 1, S_RSTAT, 0, r); check(r == 1, "R10 R3", r, 1);

    // basic range command with notification
    submit(0, 32'h0000_8001, 32'h1000, 32'h400, 0, "R3");
    sync(0);
    bus(0, 0, S_QSTAT, 0, r); check(r == 4, "R8", r, 4);
    bus(0, 1, S_QSTAT, 0, r); check(r == 0, "R8", r, 0);
    bus(1, 0, S_QSTAT, 4, r);
    bus(0, 0, S_QSTAT, 0, r); check(r == 0, "R8 clear", r, 0);

    // lock contention
    bus(1, 0, S_MODE, 32'h0000_0002, r);
    bus(1, 1, S_MODE, 32'h0000_8000, r);
    bus(1, 1, S_ADDR, 32'hDEAD, r);
    bus(1, 0, S_ADDR, 32'h2000, r);
    bus(1, 0, S_SIZE, 32'h80, r);
    bus(0, 1, S_RSTAT, 0, r); check(r == 1, "R2 R3", r, 1);
    bus(0, 0, S_RSTAT, 0, r); check(r == 0, "R2", r, 0);
    exp_q.push_back('{op: 2'd2, whole: 1'b0, addr: 32'h2000, size: 32'h80, cpu: 1'b0});
    bus(0, 1, S_RSTAT, 0, r); check(r == 1, "R3 released", r, 1);
    // whole-cache command ignores address and size, no notification
    submit(1, 32'h0002_0000, 32'h5555, 32'h66, 0, "R1");
    sync(1);
    bus(0, 1, S_QSTAT, 0, r); check(r == 0, "R8 no notify", r, 0);
    bus(0, 0, S_QSTAT, 0, r); check(r == 0, "R8 other cpu", r, 0);

    // fill the queue: one in the engine, DEPTH waiting, next refused
    for (int i = 0; i < DEPTH + 1; i++)
      submit(i % 2, 32'h0000_0002, 32'h10000 + 32'(i) * 32'h100, 32'h40, 0, "R6");
    submit(1, 32'h0000_8001, 32'h9999, 32'h40, 2, "R5");
    sync(0);
    bus(0, 1, S_QSTAT, 0, r); check(r == 0, "R4 refused not run", r, 0);
    check(n_disp == 8 && n_done == 8, "R4", n_disp, 8);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule